// File: doc/BRIEF.md
# PC-Relative Literal Load Unit

This unit executes one class of load instruction whose data address is derived from the instruction's own program counter. Each 32-bit instruction word is presented together with its 64-bit PC. Words outside the literal-load class are dropped without side effects. For a matching word, the unit adds a scaled, sign-extended 19-bit word offset to the PC and issues one read request on a valid/ready memory port. When the response arrives, the unit formats the data according to the two-bit opcode and writes it to the register-file write port.

The opcode selects one of four behaviours:

- a 4-byte load that is zero-extended;
- an 8-byte load;
- a 4-byte load that is sign-extended;
- a prefetch hint.

A prefetch sends its request with the destination field reused as a hint code, and it never writes a register. While an instruction is in flight the unit is busy and accepts no new word. A constant-time flag captured with the instruction travels with the request, so the memory side can honour a data-independent timing mode. The unit's own formatting stage always takes the same number of cycles, whatever the data.

Top module: `lit_load_unit`

## Requirements
- R1: An instruction word is taken only when bits 29:24 equal 6'b011000; any other word presented while idle causes no request, no writeback and no busy cycle.
- R2: The request address is the instruction's PC plus the bits 23:5 immediate shifted left by two and sign-extended to 64 bits, with 64-bit wraparound.
- R3: Opcode bits 31:30 = 2'b00 issue a request with req_size 0 (4 bytes) and write back the low 32 response bits zero-extended.
- R4: Opcode 2'b01 issues a request with req_size 1 (8 bytes) and writes back all 64 response bits unchanged.
- R5: Opcode 2'b10 issues a request with req_size 0 and writes back the low 32 response bits sign-extended from bit 31.
- R6: Opcode 2'b11 issues a request with req_prefetch 1, req_size 0 and req_hint equal to bits 4:0; there is no writeback, and busy falls in the cycle after the request handshake.
- R7: While req_valid is high and req_ready is low, req_valid stays high and every request field holds its value.
- R8: After reset, insn_ready is 1 and busy, req_valid and wb_valid are 0. From acceptance until completion, busy is 1 and insn_ready is 0, and a word presented in that interval is refused without altering the request in flight.
- R9: For each load, exactly one response is consumed. wb_valid pulses for one cycle, in the cycle after the response, carrying wb_reg equal to bits 4:0. A response presented while no load is waiting is ignored.
- R10: req_const_time equals the mode input sampled when the instruction is accepted. The response-to-writeback latency is one cycle for every data value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Unit can accept an instruction |
| insn_word | input | 32 | Instruction encoding |
| insn_pc | input | 64 | Address of the instruction |
| const_time_mode | input | 1 | Data-independent timing mode |
| busy | output | 1 | Instruction in flight |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 64 | Target address |
| req_size | output | 1 | 0 = 4 bytes, 1 = 8 bytes |
| req_prefetch | output | 1 | Request is a prefetch hint |
| req_hint | output | 5 | Prefetch operation code |
| req_const_time | output | 1 | Constant-time request flag |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 64 | Read data |
| wb_valid | output | 1 | Register write strobe |
| wb_reg | output | 5 | Destination register index |
| wb_data | output | 64 | Value written |

## Verification
The assertions assume three things about the memory side. It returns one response per non-prefetch request. It never answers a prefetch. A response for the load in flight arrives only after that load's request handshake. The directed tasks follow exactly this contract. The one exception is a deliberate stray response sent while the unit is idle, which checks that such a response is ignored. Each task offers an instruction, holds req_ready low for a chosen number of cycles, and then completes the handshake. Only after that does it drive a single response pulse.

// File: rtl/lit_load_pkg.sv
package lit_load_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2,
      ST_WB   = 2'd3
   } lit_state_e;

   typedef enum logic [1:0] {
      OPC_W32  = 2'b00,
      OPC_X64  = 2'b01,
      OPC_SW32 = 2'b10,
      OPC_PRF  = 2'b11
   } lit_opc_e;

   localparam logic [5:0] LIT_CLASS = 6'b011000;

endpackage

// File: rtl/lit_decode.sv
module lit_decode
   import lit_load_pkg::*;
#(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned IMM_W  = 19,
   parameter int unsigned REG_W  = 5
) (
   input  logic [31:0]       word,
   input  logic [ADDR_W-1:0] pc,
   output logic              hit,
   output lit_opc_e          opc,
   output logic [REG_W-1:0]  rt,
   output logic [ADDR_W-1:0] addr
);
   localparam int unsigned IMM_LO = REG_W;
   localparam int unsigned IMM_HI = REG_W + IMM_W - 1;
   localparam int unsigned OFF_W  = IMM_W + 2;
   localparam int unsigned EXT_W  = ADDR_W - OFF_W;

   generate
      if (IMM_HI != 23) begin : g_bad_layout
         $error("lit_decode: immediate and register fields must fill bits 23:0");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("lit_decode: address narrower than the offset");
      end
   endgenerate

   logic [IMM_W-1:0]  imm;
   logic [ADDR_W-1:0] offset;

   assign hit    = (word[29:24] == LIT_CLASS);
   assign opc    = lit_opc_e'(word[31:30]);
   assign rt     = word[REG_W-1:0];
   assign imm    = word[IMM_HI:IMM_LO];
   assign offset = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
   assign addr   = pc + offset;

endmodule

// File: rtl/lit_extend.sv
module lit_extend
   import lit_load_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  lit_opc_e          opc,
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] result
);
   localparam int unsigned HALF = DATA_W / 2;

   generate
      if (DATA_W % 2 != 0 || HALF < 8) begin : g_bad_width
         $error("lit_extend: data width must be even and at least 16");
      end
   endgenerate

   always_comb begin
      unique case (opc)
         OPC_W32:  result = {{HALF{1'b0}}, raw[HALF-1:0]};
         OPC_X64:  result = raw;
         OPC_SW32: result = {{HALF{raw[HALF-1]}}, raw[HALF-1:0]};
         OPC_PRF:  result = '0;
      endcase
   end

endmodule

// File: rtl/lit_load_unit.sv
module lit_load_unit
   import lit_load_pkg::*;
#(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned DATA_W = 64,
   parameter int unsigned IMM_W  = 19,
   parameter int unsigned REG_W  = 5,
   parameter bit          REG_WB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_valid,
   output logic              insn_ready,
   input  logic [31:0]       insn_word,
   input  logic [ADDR_W-1:0] insn_pc,
   input  logic              const_time_mode,
   output logic              busy,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic              req_size,
   output logic              req_prefetch,
   output logic [REG_W-1:0]  req_hint,
   output logic              req_const_time,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              wb_valid,
   output logic [REG_W-1:0]  wb_reg,
   output logic [DATA_W-1:0] wb_data
);

   generate
      if (DATA_W != 64) begin : g_bad_data
         $error("lit_load_unit: data path must be 64 bits");
      end
   endgenerate

   logic              dec_hit;
   lit_opc_e          dec_opc;
   logic [REG_W-1:0]  dec_rt;
   logic [ADDR_W-1:0] dec_addr;

   lit_decode #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .REG_W(REG_W)) u_decode (
      .word (insn_word),
      .pc   (insn_pc),
      .hit  (dec_hit),
      .opc  (dec_opc),
      .rt   (dec_rt),
      .addr (dec_addr)
   );

   lit_state_e        state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   lit_opc_e          opc_q;
   logic [REG_W-1:0]  rt_q;
   logic              ct_q;
   logic              take;
   logic              rsp_take;

   assign take     = insn_valid && (state_q == ST_IDLE) && dec_hit;
   assign rsp_take = (state_q == ST_WAIT) && rsp_valid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (take) state_d = ST_REQ;
         ST_REQ:  if (req_ready) state_d = (opc_q == OPC_PRF) ? ST_IDLE : ST_WAIT;
         ST_WAIT: if (rsp_valid) state_d = REG_WB ? ST_WB : ST_IDLE;
         ST_WB:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         opc_q   <= OPC_W32;
         rt_q    <= '0;
         ct_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (take) begin
            addr_q <= dec_addr;
            opc_q  <= dec_opc;
            rt_q   <= dec_rt;
            ct_q   <= const_time_mode;
         end
      end
   end

   logic [DATA_W-1:0] ext_data;

   lit_extend #(.DATA_W(DATA_W)) u_extend (
      .opc    (opc_q),
      .raw    (rsp_data),
      .result (ext_data)
   );

   generate
      if (REG_WB) begin : g_wb_reg
         logic [DATA_W-1:0] wb_data_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wb_data_q <= '0;
            else if (rsp_take) wb_data_q <= ext_data;
         end
         assign wb_valid = (state_q == ST_WB);
         assign wb_data  = wb_data_q;

         a_r10_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && !req_valid && !wb_valid && rsp_valid) |=> wb_valid);
      end else begin : g_wb_comb
         assign wb_valid = rsp_take;
         assign wb_data  = ext_data;
      end
   endgenerate

   assign insn_ready     = (state_q == ST_IDLE);
   assign busy           = (state_q != ST_IDLE);
   assign req_valid      = (state_q == ST_REQ);
   assign req_addr       = addr_q;
   assign req_size       = (opc_q == OPC_X64);
   assign req_prefetch   = (opc_q == OPC_PRF);
   assign req_hint       = rt_q;
   assign req_const_time = ct_q;
   assign wb_reg         = rt_q;

   a_r1_ignore_other: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_ready && !dec_hit) |=> !busy);

   a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                     && $stable(req_prefetch) && $stable(req_size)));

   a_r6_prefetch_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_prefetch) |=> (!busy && !wb_valid));

   a_r8_refuse_keeps_req: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && insn_valid) |=> $stable(req_addr));

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |=> !wb_valid);

   a_r9_no_wb_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wb_valid);

endmodule

// File: tb/lit_load_unit_test.sv
`timescale 1ns/1ps
module lit_load_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic        insn_ready;
   logic [31:0] insn_word = '0;
   logic [63:0] insn_pc = '0;
   logic        const_time_mode = 1'b0;
   logic        busy;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [63:0] req_addr;
   logic        req_size;
   logic        req_prefetch;
   logic [4:0]  req_hint;
   logic        req_const_time;
   logic        rsp_valid = 1'b0;
   logic [63:0] rsp_data = '0;
   logic        wb_valid;
   logic [4:0]  wb_reg;
   logic [63:0] wb_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lit_load_unit uut (
      .clk(clk), .rst_n(rst_n),
      .insn_valid(insn_valid), .insn_ready(insn_ready),
      .insn_word(insn_word), .insn_pc(insn_pc),
      .const_time_mode(const_time_mode), .busy(busy),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_size(req_size), .req_prefetch(req_prefetch), .req_hint(req_hint),
      .req_const_time(req_const_time),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] enc(input logic [1:0] opc, input logic [18:0] imm,
                                       input logic [4:0] rt);
      return {opc, 6'b011000, imm, rt};
   endfunction

   function automatic logic [63:0] target(input logic [63:0] pc, input logic [18:0] imm);
      return pc + {{43{imm[18]}}, imm, 2'b00};
   endfunction

   // Full load or prefetch: offer, hold, handshake, respond, check writeback.
   task automatic do_load(input logic [1:0] opc, input logic [18:0] imm, input logic [4:0] rt,
                          input logic [63:0] pc, input bit dit, input int hold,
                          input logic [63:0] data, input logic [63:0] exp_wb, input string tag);
      @(negedge clk);
      insn_valid = 1'b1; insn_word = enc(opc, imm, rt); insn_pc = pc; const_time_mode = dit;
      @(negedge clk);
      insn_valid = 1'b0;
      chk("R8 busy after accept", {63'd0, busy}, 64'd1);
      chk("R2 address", req_addr, target(pc, imm));
      chk({tag, " size"}, {63'd0, req_size}, {63'd0, opc == 2'b01});
      chk("R6 prefetch flag", {63'd0, req_prefetch}, {63'd0, opc == 2'b11});
      chk("R10 const flag", {63'd0, req_const_time}, {63'd0, dit});
      if (opc == 2'b11) chk("R6 hint", {59'd0, req_hint}, {59'd0, rt});
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         chk("R7 valid held", {63'd0, req_valid}, 64'd1);
         chk("R7 address held", req_addr, target(pc, imm));
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      chk("R7 request dropped", {63'd0, req_valid}, 64'd0);
      if (opc == 2'b11) begin
         chk("R6 not busy", {63'd0, busy}, 64'd0);
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6 no writeback", {63'd0, wb_valid}, 64'd0);
         end
      end else begin
         chk("R9 no early wb", {63'd0, wb_valid}, 64'd0);
         rsp_valid = 1'b1; rsp_data = data;
         @(negedge clk);
         rsp_valid = 1'b0; rsp_data = ~data;
         chk("R10 wb one cycle after rsp", {63'd0, wb_valid}, 64'd1);
         chk("R9 wb reg", {59'd0, wb_reg}, {59'd0, rt});
         chk({tag, " wb data"}, wb_data, exp_wb);
         @(negedge clk);
         chk("R9 wb pulse ends", {63'd0, wb_valid}, 64'd0);
         chk("R8 idle again", {63'd0, insn_ready}, 64'd1);
      end
   endtask

   task automatic t_reset;
      chk("R8 reset ready", {63'd0, insn_ready}, 64'd1);
      chk("R8 reset busy", {63'd0, busy}, 64'd0);
      chk("R8 reset req", {63'd0, req_valid}, 64'd0);
      chk("R8 reset wb", {63'd0, wb_valid}, 64'd0);
   endtask

   task automatic t_nonmatch;
      @(negedge clk);
      insn_valid = 1'b1; insn_word = {2'b00, 6'b011001, 19'h12, 5'd3}; insn_pc = 64'h100;
      @(negedge clk);
      insn_valid = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk("R1 no request", {63'd0, req_valid}, 64'd0);
         chk("R1 not busy", {63'd0, busy}, 64'd0);
         chk("R1 no wb", {63'd0, wb_valid}, 64'd0);
         @(negedge clk);
      end
   endtask

   task automatic t_stray_rsp;
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = 64'hAAAA_5555_AAAA_5555;
      @(negedge clk);
      rsp_valid = 1'b0;
      chk("R9 stray rsp ignored", {63'd0, wb_valid}, 64'd0);
      chk("R9 stray rsp no busy", {63'd0, busy}, 64'd0);
   endtask

   task automatic t_refuse;
      logic [63:0] a0;
      a0 = target(64'h8000, 19'h10);
      @(negedge clk);
      insn_valid = 1'b1; insn_word = enc(2'b01, 19'h10, 5'd9); insn_pc = 64'h8000;
      @(negedge clk);
      insn_word = enc(2'b00, 19'h20, 5'd4); insn_pc = 64'h9000;
      chk("R8 ready low while busy", {63'd0, insn_ready}, 64'd0);
      @(negedge clk);
      chk("R8 request kept", req_addr, a0);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      insn_valid = 1'b0;
      rsp_valid = 1'b1; rsp_data = 64'h1111_2222_3333_4444;
      @(negedge clk);
      rsp_valid = 1'b0;
      chk("R8 first load wb", wb_data, 64'h1111_2222_3333_4444);
      chk("R8 first load reg", {59'd0, wb_reg}, 64'd9);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R8 refused word not issued", {63'd0, req_valid}, 64'd0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      do_load(2'b00, 19'd3, 5'd7, 64'h4000, 1'b0, 0,
              64'hDEAD_BEEF_8000_0001, 64'h0000_0000_8000_0001, "R3");
      do_load(2'b01, 19'h7FFFF, 5'd31, 64'h1000, 1'b0, 2,
              64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, "R4");
      do_load(2'b10, 19'h40000, 5'd1, 64'h0, 1'b0, 1,
              64'h0000_0000_8000_0001, 64'hFFFF_FFFF_8000_0001, "R5");
      do_load(2'b10, 19'h3FFFF, 5'd2, 64'h10, 1'b1, 0,
              64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF, "R5");
      do_load(2'b00, 19'd8, 5'd0, 64'h2000, 1'b1, 0,
              64'h0, 64'h0, "R10");
      do_load(2'b11, 19'd1, 5'b10101, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, 3,
              64'h0, 64'h0, "R6");
      t_nonmatch();
      t_stray_rsp();
      do_load(2'b01, 19'd5, 5'd12, 64'h300, 1'b0, 0,
              64'hFEDC_BA98_7654_3210, 64'hFEDC_BA98_7654_3210, "R4");
      t_refuse();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule